// File: doc/BRIEF.md
# Overpower Hiccup Fault Timer

This block guards a power-factor-correction stage against a sustained overload. When the estimated power stays above its rating, the output voltage sags. If it sags far enough, the mode sequencer falls back into start-up. Only when both of these hold together, the overpower flag and the undervoltage/start-up indication, does the block start a protection window. The window is measured in ticks of a 1 ms timebase.

If the combined condition lasts for the whole trip window (112 ticks by default), the block requests that the gate drive be turned off. It holds that request for a long fixed off period (3000 ticks by default), whatever its inputs do. It then returns to idle so that switching can be retried. If the overload is still there, the window starts again and the off/retry cycle repeats without limit. If the condition clears before the trip, the window is abandoned and its count is dropped.

The controller is a three-state machine. `IDLE` goes to `ARMED` when the qualifier is seen. `ARMED` goes back to `IDLE` if the qualifier drops, or to `HICCUP_OFF` when the trip window completes. `HICCUP_OFF` goes to `IDLE` when the off period completes.

Top module: `hiccup_guard`

## Requirements
- R1: After reset, `gate_disable` and `fault_status` are both 0 and the machine is in `IDLE`.
- R2: The qualifier is `overpower` AND `uv_startup`. Either flag alone, with or without ticks, leaves both outputs at 0.
- R3: In `IDLE`, a high qualifier moves the machine to `ARMED` on the next clock edge. `fault_status` reads 1 from then on and `gate_disable` stays 0.
- R4: In `ARMED`, only ticks that arrive while the qualifier is high are counted. Counting starts with the cycle after arming. `gate_disable` reads 1 from the edge of the TRIP_MS-th such tick onward.
- R5: If the qualifier drops while `ARMED`, the machine returns to `IDLE` on the next edge. The count is cleared, so a later arming again needs the full TRIP_MS ticks.
- R6: In `HICCUP_OFF`, `gate_disable` and `fault_status` stay 1 for exactly OFF_MS ticks, whatever `overpower` and `uv_startup` do.
- R7: At the edge of the OFF_MS-th tick the machine returns to `IDLE` with both outputs at 0. It re-arms only when the qualifier is seen again, so a persisting fault repeats the trip/off cycle indefinitely.
- R8: `gate_disable` is never 1 while `fault_status` is 0.
- R9: With `tick_1ms` held low, the machine never leaves `ARMED` for `HICCUP_OFF`, nor `HICCUP_OFF` for `IDLE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond of timebase |
| overpower | input | 1 | Estimated power is above the rated level |
| uv_startup | input | 1 | Output undervoltage / start-up mode re-entered |
| gate_disable | output | 1 | Request to hold the gate drive off |
| fault_status | output | 1 | Protection window running or hiccup off period active |

## Verification
Each flag is driven alone to show that neither one can arm the timer. The qualifier is held steadily with a tick on every cycle; this pins the trip edge to exactly the 112th tick and the retry edge to exactly the 3000th. A drop of the qualifier on the last tick before the trip tells a true count reset apart from a paused count. Random phases mix sparse ticks, chattering flags and glitches during the off period; these separate tick-gated counting from cycle counting and show that the off period ignores its inputs.

// File: rtl/hiccup_guard_pkg.sv
package hiccup_guard_pkg;
    typedef enum logic [1:0] {
        IDLE       = 2'd0,
        ARMED      = 2'd1,
        HICCUP_OFF = 2'd2
    } hg_state_t;
endpackage

// File: rtl/hiccup_tick_window.sv
module hiccup_tick_window #(
    parameter int LIMIT = 112
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign done = inc && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || done) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
    import hiccup_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      qual,
    input  logic      trip_done,
    input  logic      off_done,
    output hg_state_t state,
    output logic      gate_off,
    output logic      fault
);
    hg_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            IDLE:       if (qual) nxt = ARMED;
            ARMED: begin
                if (!qual)          nxt = IDLE;
                else if (trip_done) nxt = HICCUP_OFF;
            end
            HICCUP_OFF: if (off_done) nxt = IDLE;
            default:    nxt = IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= IDLE;
        else        state <= nxt;
    end

    // registered outputs decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_off <= 1'b0;
            fault    <= 1'b0;
        end else begin
            gate_off <= (nxt == HICCUP_OFF);
            fault    <= (nxt != IDLE);
        end
    end
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
    import hiccup_guard_pkg::*;
#(
    parameter int TRIP_MS = 112,
    parameter int OFF_MS  = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1ms,
    input  logic overpower,
    input  logic uv_startup,
    output logic gate_disable,
    output logic fault_status
);
    hg_state_t state;
    logic      qual;
    logic      trip_done;
    logic      off_done;
    logic      in_armed;
    logic      in_off;

    assign qual     = overpower && uv_startup;
    assign in_armed = (state == ARMED);
    assign in_off   = (state == HICCUP_OFF);

    hiccup_tick_window #(.LIMIT(TRIP_MS)) u_trip (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_armed || !qual),
        .inc   (tick_1ms && in_armed && qual),
        .done  (trip_done)
    );

    hiccup_tick_window #(.LIMIT(OFF_MS)) u_off (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_off),
        .inc   (tick_1ms && in_off),
        .done  (off_done)
    );

    hiccup_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual      (qual),
        .trip_done (trip_done),
        .off_done  (off_done),
        .state     (state),
        .gate_off  (gate_disable),
        .fault     (fault_status)
    );
endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_1ms,
    input logic overpower,
    input logic uv_startup,
    input logic gate_disable,
    input logic fault_status
);
    AST_IDLE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_status && !(overpower && uv_startup)) |=> !fault_status); // R2
    AST_ARM_ON_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_status && overpower && uv_startup) |=> (fault_status && !gate_disable)); // R3
    AST_DROP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status && !gate_disable && !(overpower && uv_startup)) |=> !fault_status); // R5
    AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_disable && !tick_1ms) |=> (gate_disable && fault_status)); // R6
    AST_RETRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_disable) |-> !fault_status); // R7
    AST_GATE_IMPLIES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        gate_disable |-> fault_status); // R8
    AST_NO_TICK_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status && !gate_disable && !tick_1ms) |=> !gate_disable); // R9
endmodule

bind hiccup_guard hiccup_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_1ms     (tick_1ms),
    .overpower    (overpower),
    .uv_startup   (uv_startup),
    .gate_disable (gate_disable),
    .fault_status (fault_status)
);

// File: tb/hiccup_guard_test.sv
module hiccup_guard_test;
    localparam int TRIP = 112;
    localparam int OFFP = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 1'b0;
    logic overpower = 1'b0;
    logic uv_startup = 1'b0;
    logic gate_disable;
    logic fault_status;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int m_st = 0;
    int m_cnt = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    hiccup_guard #(.TRIP_MS(TRIP), .OFF_MS(OFFP)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .overpower(overpower), .uv_startup(uv_startup),
        .gate_disable(gate_disable), .fault_status(fault_status)
    );

    function automatic logic exp_gate(int st);
        return st == 2;
    endfunction

    function automatic logic exp_fault(int st);
        return st != 0;
    endfunction

    // requirement-level model: 0 idle, 1 window running, 2 hiccup off
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st  <= 0;
            m_cnt <= 0;
        end else begin
            case (m_st)
                0: if (overpower && uv_startup) begin m_st <= 1; m_cnt <= 0; end
                1: begin
                    if (!(overpower && uv_startup)) begin m_st <= 0; m_cnt <= 0; end
                    else if (tick_1ms) begin
                        if (m_cnt + 1 == TRIP) begin m_st <= 2; m_cnt <= 0; end
                        else m_cnt <= m_cnt + 1;
                    end
                end
                default: if (tick_1ms) begin
                    if (m_cnt + 1 == OFFP) begin m_st <= 0; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            endcase
        end
    end

    task automatic check(string req, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b cycle=%0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // one cycle: compare against the model, then drive new inputs
    task automatic step(logic op, logic uv, logic tk);
        @(negedge clk);
        cyc++;
        if (rst_n) begin
            check(tag, gate_disable, exp_gate(m_st), "gate_disable");
            check(tag, fault_status, exp_fault(m_st), "fault_status");
        end
        overpower  = op;
        uv_startup = uv;
        tick_1ms   = tk;
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int seed;
        seed = 11;
        void'($urandom(seed));
        repeat (3) step(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", gate_disable, 1'b0, "gate after reset");
        check("R1", fault_status, 1'b0, "fault after reset");

        // R2: single flags never arm
        tag = "R2";
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b1);
        check("R2", fault_status, 1'b0, "fault with one flag");

        // R3/R4: arm, then exact trip on the 112th tick
        tag = "R3";
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        check("R3", fault_status, 1'b1, "armed fault");
        check("R3", gate_disable, 1'b0, "armed gate");
        tag = "R4";
        for (int i = 0; i < TRIP - 1; i++) step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        check("R4", gate_disable, 1'b0, "gate after 111 ticks");
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        check("R4", gate_disable, 1'b1, "gate after 112 ticks");

        // R6: off period held despite inputs dropping
        tag = "R6";
        for (int i = 0; i < OFFP - 1; i++) step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        check("R6", gate_disable, 1'b1, "gate after 2999 off ticks");
        // R7: retry to idle on the 3000th tick
        tag = "R7";
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        check("R7", gate_disable, 1'b0, "gate after off period");
        check("R7", fault_status, 1'b0, "fault after off period");

        // R5: drop on the last tick before trip, then full window needed again
        tag = "R5";
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < TRIP - 1; i++) step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        check("R5", fault_status, 1'b0, "fault after drop");
        for (int i = 0; i < TRIP - 1; i++) step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        check("R5", gate_disable, 1'b0, "no trip after restart");

        // R9: no ticks, no trip
        tag = "R9";
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b0);
        check("R9", gate_disable, 1'b0, "gate without ticks");

        // R7: persisting fault repeats the hiccup
        tag = "R7";
        for (int i = 0; i < 2 * (TRIP + OFFP) + 10; i++) step(1'b1, 1'b1, 1'b1);

        // random phases, checked against the model each cycle (R8 covered too)
        tag = "R8";
        for (int ph = 0; ph < 30; ph++) begin
            int len = 50 + int'($urandom % 400);
            int tk_mod = 1 + int'($urandom % 3);
            int mode = int'($urandom % 4);
            for (int i = 0; i < len; i++) begin
                logic op, uv;
                op = (mode == 0) ? 1'b1 : ($urandom % 8 != 0);
                uv = (mode == 1) ? ($urandom % 2 == 0) : ($urandom % 16 != 0);
                step(op, uv, ($urandom % tk_mod) == 0);
            end
        end
        for (int i = 0; i < 8000; i++) step(1'b1, 1'b1, ($urandom % 2) == 0);
        finish_run();
    end
endmodule